// File: doc/BRIEF.md
# Match-Compare Interval Timer

This block is a 32-bit interval timer that sits on a simple register bus. A programmable prescaler divides the clock. Each time the prescaler wraps, it advances a timer count. The count is compared against one match value. A match control register decides what a match does. It can set an interrupt flag, send the count back to zero, do both, or do neither.

The interrupt output is a level. It stays high until software writes a one to the flag bit. Writing a zero to the flag has no effect. If a match and a clearing write land in the same cycle, the match wins, so no event is lost. Bus writes take effect on the clock edge. Reads return the addressed register combinationally in the same cycle.

Top module: `match_timer`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low; word index 7 is unmapped and always reads zero.
- R2: While CTRL (word 0) bit 0 is 0, the timer count (word 1) and the prescale count (word 3, read-only) keep their values.
- R3: With prescale limit P in word 2, the timer count advances once every P+1 clocks, and the prescale count reads k mod (P+1) after k running clocks. P=0 advances the count every clock.
- R4: With MCTL (word 5) bit 1 set and match value N in word 4, the count reads N, then 0 on the next advance, so it cycles through N+1 values.
- R5: With MCTL bit 1 clear, the count moves on past the match value to N+1.
- R6: With MCTL bit 0 set, a match sets FLAG (word 6) bit 0 on the advance that leaves N. With MCTL bit 0 clear, a match leaves the flag at 0.
- R7: `irq_o` is high exactly when the flag and MCTL bit 0 are both 1. It stays high across later clocks until the flag is cleared.
- R8: Writing word 6 with bit 0 = 1 clears the flag. A write with bit 0 = 0 leaves the flag unchanged.
- R9: A clearing write in the same cycle as a flag-setting match leaves the flag set.
- R10: With no reset on match, the count wraps from 0xFFFFFFFF to 0.
- R11: A bus write to word 1 loads the count. This load takes priority over counting in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word index of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions assume that every bus control input holds a defined 0 or 1 at each rising edge after reset. They also assume a write is a one-cycle pulse, so a count load and a flag clear each cover exactly one edge. The stimulus changes every input only on falling edges and drops `bus_sel` between accesses. Scenarios that line a clearing write up with a match count the edges since the enabling write, so the collision falls on a known edge.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int unsigned MT_AW = 3;

  typedef enum logic [MT_AW-1:0] {
    REG_CTRL  = 3'd0,
    REG_COUNT = 3'd1,
    REG_PSCL  = 3'd2,
    REG_PCNT  = 3'd3,
    REG_MATCH = 3'd4,
    REG_MCTL  = 3'd5,
    REG_FLAG  = 3'd6,
    REG_RSVD  = 3'd7
  } reg_idx_e;

  localparam int unsigned CTRL_RUN_BIT   = 0;
  localparam int unsigned MCTL_IRQ_BIT   = 0;
  localparam int unsigned MCTL_RST_BIT   = 1;
  localparam int unsigned FLAG_MATCH_BIT = 0;
  localparam int unsigned MCTL_W         = 2;
endpackage

// File: rtl/mt_regfile.sv
module mt_regfile
  import mt_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [MT_AW-1:0] bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [DW-1:0]    cnt_val,
  input  logic [DW-1:0]    pcnt_val,
  input  logic             match_evt,
  output logic             run,
  output logic             irq_en,
  output logic             rst_en,
  output logic             flag,
  output logic             cnt_load,
  output logic             clr_req,
  output logic [DW-1:0]    pscl_val,
  output logic [DW-1:0]    match_val
);
  logic              run_q;
  logic [MCTL_W-1:0] mctl_q;
  logic [DW-1:0]     pscl_q;
  logic [DW-1:0]     match_q;
  logic              flag_q;

  function automatic logic wr_hit(input reg_idx_e idx);
    return bus_sel && bus_wr && (reg_idx_e'(bus_addr) == idx);
  endfunction

  // set has priority over clear so a colliding event survives
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  assign cnt_load = wr_hit(REG_COUNT);
  assign clr_req  = wr_hit(REG_FLAG) && bus_wdata[FLAG_MATCH_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      mctl_q  <= '0;
      pscl_q  <= '0;
      match_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      if (wr_hit(REG_CTRL))  run_q   <= bus_wdata[CTRL_RUN_BIT];
      if (wr_hit(REG_MCTL))  mctl_q  <= bus_wdata[MCTL_W-1:0];
      if (wr_hit(REG_PSCL))  pscl_q  <= bus_wdata;
      if (wr_hit(REG_MATCH)) match_q <= bus_wdata;
      flag_q <= flag_next(flag_q, match_evt && mctl_q[MCTL_IRQ_BIT], clr_req);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (reg_idx_e'(bus_addr))
        REG_CTRL:  bus_rdata = {{(DW-1){1'b0}}, run_q};
        REG_COUNT: bus_rdata = cnt_val;
        REG_PSCL:  bus_rdata = pscl_q;
        REG_PCNT:  bus_rdata = pcnt_val;
        REG_MATCH: bus_rdata = match_q;
        REG_MCTL:  bus_rdata = {{(DW-MCTL_W){1'b0}}, mctl_q};
        REG_FLAG:  bus_rdata = {{(DW-1){1'b0}}, flag_q};
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign run       = run_q;
  assign irq_en    = mctl_q[MCTL_IRQ_BIT];
  assign rst_en    = mctl_q[MCTL_RST_BIT];
  assign flag      = flag_q;
  assign pscl_val  = pscl_q;
  assign match_val = match_q;
endmodule

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [DW-1:0] limit,
  output logic [DW-1:0] pcnt,
  output logic          tick
);
  logic [DW-1:0] pcnt_q;

  // at or beyond the limit counts as wrap, so lowering the limit mid-count is safe
  function automatic logic at_limit(input logic [DW-1:0] c, input logic [DW-1:0] l);
    return c >= l;
  endfunction

  assign tick = run && at_limit(pcnt_q, limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pcnt_q <= '0;
    else if (tick)   pcnt_q <= '0;
    else if (run)    pcnt_q <= pcnt_q + DW'(1);
  end

  assign pcnt = pcnt_q;
endmodule

// File: rtl/mt_counter.sv
module mt_counter #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic [DW-1:0] match_val,
  input  logic          rst_en,
  output logic [DW-1:0] count,
  output logic          match_evt
);
  logic [DW-1:0] count_q;

  function automatic logic [DW-1:0] next_count(input logic [DW-1:0] cur, input logic back_to_zero);
    return back_to_zero ? '0 : cur + DW'(1);
  endfunction

  assign match_evt = tick && (count_q == match_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count_q <= '0;
    else if (load)  count_q <= load_val;
    else if (tick)  count_q <= next_count(count_q, match_evt && rst_en);
  end

  assign count = count_q;
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mt_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [MT_AW-1:0] bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             irq_o
);
  logic          run;
  logic          tick;
  logic          match_evt;
  logic          irq_en;
  logic          rst_en;
  logic          flag;
  logic          cnt_load;
  logic          clr_req;
  logic [DW-1:0] pscl_val;
  logic [DW-1:0] match_val;
  logic [DW-1:0] count;
  logic [DW-1:0] pcnt;

  mt_regfile #(.DW(DW)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_val(count), .pcnt_val(pcnt), .match_evt(match_evt),
    .run(run), .irq_en(irq_en), .rst_en(rst_en), .flag(flag),
    .cnt_load(cnt_load), .clr_req(clr_req),
    .pscl_val(pscl_val), .match_val(match_val)
  );

  mt_prescaler #(.DW(DW)) presc_i (
    .clk(clk), .rst_n(rst_n), .run(run), .limit(pscl_val),
    .pcnt(pcnt), .tick(tick)
  );

  mt_counter #(.DW(DW)) cnt_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .load(cnt_load), .load_val(bus_wdata),
    .match_val(match_val), .rst_en(rst_en),
    .count(count), .match_evt(match_evt)
  );

  assign irq_o = flag & irq_en;
endmodule

// File: rtl/mt_checker.sv
module mt_checker #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          tick,
  input logic          cnt_load,
  input logic          match_evt,
  input logic          rst_en,
  input logic          irq_en,
  input logic          clr_req,
  input logic          flag,
  input logic          irq,
  input logic [DW-1:0] count
);
  AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run); // R2
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !cnt_load |=> $stable(count)); // R2
  AST_TICK_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !cnt_load && !(match_evt && rst_en) |=> count == $past(count) + DW'(1)); // R3
  AST_MATCH_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt && rst_en && !cnt_load |=> count == '0); // R4
  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt && irq_en |=> flag); // R9
  AST_NO_SPURIOUS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !flag && !(match_evt && irq_en) |=> !flag); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr_req |=> flag); // R7
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req && !(match_evt && irq_en) |=> !flag); // R8
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag); // R7
endmodule

bind match_timer mt_checker #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .cnt_load(cnt_load),
  .match_evt(match_evt), .rst_en(rst_en), .irq_en(irq_en),
  .clr_req(clr_req), .flag(flag), .irq(irq_o), .count(count)
);

// File: tb/match_timer_tb_top.sv
module match_timer_tb_top;
  localparam int unsigned DW = 32;
  localparam logic [2:0] A_CTRL = 3'd0, A_COUNT = 3'd1, A_PSCL = 3'd2,
    A_PCNT = 3'd3, A_MATCH = 3'd4, A_MCTL = 3'd5, A_FLAG = 3'd6, A_RSVD = 3'd7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  match_timer #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    bus_sel = 1'b0; bus_wr = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [DW-1:0] v;
    do_reset();
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R1 register reset", v, '0);
    end
    check("R1 irq reset", DW'(irq_o), '0);
  endtask

  task automatic t_prescale(input int p, input int n);
    logic [DW-1:0] v;
    do_reset();
    wr(A_PSCL, DW'(p));
    wr(A_MATCH, '1);
    wr(A_CTRL, 1);
    idle(n);
    rd(A_COUNT, v);
    check("R3 count rate", v, DW'(n / (p + 1)));
    rd(A_PCNT, v);
    check("R3 prescale count", v, DW'(n % (p + 1)));
  endtask

  task automatic t_hold();
    logic [DW-1:0] v;
    do_reset();
    wr(A_MATCH, '1);
    wr(A_PSCL, 2);
    wr(A_CTRL, 1);
    idle(6);
    wr(A_CTRL, 0);          // running edge 7: count 2, prescale count 1
    idle(5);
    rd(A_COUNT, v);
    check("R2 count held", v, 2);
    rd(A_PCNT, v);
    check("R2 prescale held", v, 1);
  endtask

  task automatic t_reset_on_match();
    logic [DW-1:0] v;
    do_reset();
    wr(A_MATCH, 3);
    wr(A_MCTL, 3);
    wr(A_CTRL, 1);
    idle(3);
    rd(A_COUNT, v);  check("R4 count at match", v, 3);
    rd(A_FLAG, v);   check("R6 flag before match", v, 0);
    check("R7 irq before match", DW'(irq_o), 0);
    idle(1);
    rd(A_COUNT, v);  check("R4 count zero after match", v, 0);
    rd(A_FLAG, v);   check("R6 flag set on match", v, 1);
    check("R7 irq high", DW'(irq_o), 1);
    idle(2);
    rd(A_COUNT, v);  check("R4 period N+1", v, 2);
    check("R7 irq stays high", DW'(irq_o), 1);
  endtask

  task automatic t_no_reset();
    logic [DW-1:0] v;
    do_reset();
    wr(A_MATCH, 3);
    wr(A_MCTL, 1);
    wr(A_CTRL, 1);
    idle(5);
    rd(A_COUNT, v);  check("R5 count passes match", v, 5);
    rd(A_FLAG, v);   check("R6 flag without reset", v, 1);
  endtask

  task automatic t_irq_disabled();
    logic [DW-1:0] v;
    do_reset();
    wr(A_MATCH, 2);
    wr(A_MCTL, 2);
    wr(A_CTRL, 1);
    idle(7);
    rd(A_COUNT, v);  check("R4 reset-only wraps", v, 1);
    rd(A_FLAG, v);   check("R6 no flag when disabled", v, 0);
    check("R7 irq low when disabled", DW'(irq_o), 0);
  endtask

  task automatic t_irq_mask();
    logic [DW-1:0] v;
    do_reset();
    wr(A_MATCH, 1);
    wr(A_MCTL, 1);
    wr(A_CTRL, 1);
    idle(3);
    wr(A_CTRL, 0);
    check("R7 irq with flag and enable", DW'(irq_o), 1);
    wr(A_MCTL, 0);
    check("R7 irq masked by enable", DW'(irq_o), 0);
    rd(A_FLAG, v);   check("R7 flag kept while masked", v, 1);
  endtask

  task automatic t_w1c();
    logic [DW-1:0] v;
    do_reset();
    wr(A_MATCH, 1);
    wr(A_MCTL, 1);
    wr(A_CTRL, 1);
    idle(3);
    wr(A_CTRL, 0);
    wr(A_FLAG, 0);
    rd(A_FLAG, v);   check("R8 zero write ignored", v, 1);
    wr(A_FLAG, 32'hFFFF_FFFE);
    rd(A_FLAG, v);   check("R8 bit0 zero ignored", v, 1);
    check("R8 irq still high", DW'(irq_o), 1);
    wr(A_FLAG, 1);
    rd(A_FLAG, v);   check("R8 one clears", v, 0);
    check("R8 irq low after clear", DW'(irq_o), 0);
  endtask

  task automatic t_collision();
    logic [DW-1:0] v;
    do_reset();
    wr(A_MATCH, 3);
    wr(A_MCTL, 3);
    wr(A_CTRL, 1);
    idle(7);
    wr(A_FLAG, 1);          // clearing write lands on running edge 8, a match
    rd(A_FLAG, v);   check("R9 match wins over clear", v, 1);
    wr(A_FLAG, 1);          // edge 9, no match
    rd(A_FLAG, v);   check("R9 later clear works", v, 0);
  endtask

  task automatic t_wrap();
    logic [DW-1:0] v;
    do_reset();
    wr(A_MATCH, 5);
    wr(A_COUNT, 32'hFFFF_FFFE);
    wr(A_CTRL, 1);
    idle(2);
    rd(A_COUNT, v);  check("R10 wrap to zero", v, 0);
    idle(1);
    rd(A_COUNT, v);  check("R10 after wrap", v, 1);
  endtask

  task automatic t_load();
    logic [DW-1:0] v;
    do_reset();
    wr(A_MATCH, '1);
    wr(A_CTRL, 1);
    idle(3);
    wr(A_COUNT, 100);
    rd(A_COUNT, v);  check("R11 load wins", v, 100);
    idle(3);
    rd(A_COUNT, v);  check("R11 counts from loaded", v, 103);
  endtask

  initial begin
    t_reset_state();
    t_prescale(0, 7);
    t_prescale(3, 10);
    t_prescale(1, 9);
    t_hold();
    t_reset_on_match();
    t_no_reset();
    t_irq_disabled();
    t_irq_mask();
    t_w1c();
    t_collision();
    t_wrap();
    t_load();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule